// File: doc/BRIEF.md
# Frame Sync Alignment Monitor

This block watches an external frame sync input and judges whether its falling edge lines up with the frame boundary generated locally. Its clock runs at twice the unit-interval (UI) rate, so each cycle is half a UI. Offsets and window limits are expressed in these half-UI ticks.

A two-bit phase select moves the effective sampling point of the sync input in half-UI steps. After the shift, the block measures the signed distance from the closest local frame strobe to the sync edge. A three-bit limit code sets an acceptance window of ±(code+1) UI. Each measured edge produces a one-cycle event pulse and a registered offset. An edge that lands outside the window, or that has no frame strobe within reach, sets a sticky alarm. Only a clear pulse resets the alarm.

The recommended configuration after reset is phase select 00 and limit code 010, which gives ±3 UI. Both are plain inputs, and the integrating logic holds them.

Top module: `frame_sync_mon`

## Requirements
- R1: `sync_i` is sampled on every rising clock edge. A falling edge is recognised at the first edge where `sync_i` is sampled low after having been sampled high. Two falling edges are never recognised on consecutive cycles.
- R2: `phase_sel_i` adds a shift, in half-UI ticks, to the time of the sync edge before it is measured. The encodings are: 00 adds 0, 01 adds −1 (half UI early), 10 adds +2 (one UI late), and 11 adds +1 (half UI late).
- R3: `offset_o` is the shifted sync edge time minus the time of the closest `frame_i` strobe, in half-UI ticks, in two's complement. A positive value means the sync edge came after the strobe. When an earlier strobe and a later strobe are equally distant, the earlier one is used.
- R4: The window W, in ticks, is 2·(`limit_i`+1). A later strobe is taken into account only when it lies at most W ticks after the shifted edge.
- R5: The distance back to the last strobe saturates at 2·2^LIMIT_W+1 ticks, which is 17 with the default parameters. An edge with no usable strobe reports this saturated value. A measured offset whose magnitude exceeds W is a violation.
- R6: Each measured edge gives exactly one one-cycle `sync_evt_o` pulse. `offset_o` changes together with the pulse and holds its value until the next pulse. The pulse appears no later than W+6 cycles after the sync falling edge was sampled.
- R7: `alarm_o` rises together with the event pulse of a violating edge. It then stays high, including through later non-violating edges, until `alarm_clr_i` is sampled high. After that it reads low on the next cycle.
- R8: When a violation is registered in the same cycle that `alarm_clr_i` is high, the violation wins and `alarm_o` is high.
- R9: A sync falling edge that arrives while an earlier edge is still waiting for a later strobe is ignored. It produces no event pulse and does not change the pending measurement.
- R10: While `rst_ni` is low, `sync_evt_o`, `offset_o` and `alarm_o` are zero. The distance back to the last strobe starts out saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at twice the UI rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | External frame sync |
| frame_i | input | 1 | Local frame boundary strobe, one cycle |
| phase_sel_i | input | 2 | Sampling phase shift code |
| limit_i | input | LIMIT_W | Window code, window ±(code+1) UI |
| alarm_clr_i | input | 1 | Clear pulse for the sticky alarm |
| sync_evt_o | output | 1 | One-cycle pulse per measured sync edge |
| offset_o | output | LIMIT_W+3 | Signed offset in half-UI ticks |
| alarm_o | output | 1 | Sticky misalignment alarm |

## Verification
The bench builds the block with the default LIMIT_W of 3, so all eight window codes from ±1 UI up to ±8 UI can be reached. With this value the saturated back distance is 17 ticks, one beyond the widest window, and both edges of every window (W and W+1) can be driven with directed strobes. Every phase code is applied to the same stimulus, so each shift shows up as a different offset. Random trials mix the codes with sparse strobe patterns, and one directed case places a second sync edge inside a pending forward search.

// File: rtl/fsam_pkg.sv
package fsam_pkg;

  localparam int unsigned PH_TAPS = 4;
  localparam int unsigned NOM_TAP = 1;

  typedef enum logic [1:0] {
    PH_ON_TARGET = 2'b00,
    PH_EARLY_H   = 2'b01,
    PH_LATE_FULL = 2'b10,
    PH_LATE_H    = 2'b11
  } phase_sel_e;

  // delay tap for each phase code; NOM_TAP is the zero-shift point
  function automatic logic [1:0] tap_for(input phase_sel_e sel);
    case (sel)
      PH_EARLY_H:   return 2'd0;
      PH_ON_TARGET: return 2'd1;
      PH_LATE_H:    return 2'd2;
      default:      return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/fsam_sampler.sv
module fsam_sampler
  import fsam_pkg::*;
#(
  parameter int unsigned TAPS = PH_TAPS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sync_i,
  input  logic                    frame_i,
  input  logic [$clog2(TAPS)-1:0] tap_i,
  output logic                    edge_o,
  output logic                    frame_o
);

  // frame path latency equals the nominal tap of the sync path
  localparam int unsigned FRAME_LAT = NOM_TAP + 2;

  logic                 sync_q, sync_qq;
  logic                 fall;
  logic [TAPS-1:0]      fall_dly;
  logic [FRAME_LAT-1:0] frm_dly;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 1'b0;
      sync_qq <= 1'b0;
    end else begin
      sync_q  <= sync_i;
      sync_qq <= sync_q;
    end
  end

  assign fall = sync_qq & ~sync_q;

  generate
    if (TAPS > 1) begin : g_fall_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fall_dly <= '0;
        else         fall_dly <= {fall_dly[TAPS-2:0], fall};
      end
    end else begin : g_fall_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fall_dly <= '0;
        else         fall_dly <= fall;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frm_dly <= '0;
    else         frm_dly <= {frm_dly[FRAME_LAT-2:0], frame_i};
  end

  assign edge_o  = fall_dly[tap_i];
  assign frame_o = frm_dly[FRAME_LAT-1];

  AST_FALL_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> !fall); // R1

endmodule

// File: rtl/fsam_measure.sv
module fsam_measure #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned OFS_W = 6,
  parameter int unsigned SAT   = 17
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    edge_i,
  input  logic                    frame_i,
  input  logic [CNT_W-1:0]        win_i,
  output logic                    res_o,
  output logic                    viol_o,
  output logic signed [OFS_W-1:0] off_o
);

  logic [CNT_W-1:0] since_q, back_q, fwd_q;
  logic             pend_q, start;

  always_comb begin
    res_o  = 1'b0;
    viol_o = 1'b0;
    off_o  = '0;
    start  = 1'b0;
    if (pend_q) begin
      // ties and out-of-window forward searches fall back to the earlier strobe
      if (fwd_q >= back_q || fwd_q > win_i) begin
        res_o  = 1'b1;
        off_o  = OFS_W'(back_q);
        viol_o = back_q > win_i;
      end else if (frame_i) begin
        res_o = 1'b1;
        off_o = OFS_W'(0) - OFS_W'(fwd_q);
      end
    end else if (edge_i) begin
      if (frame_i) res_o = 1'b1;
      else         start = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= CNT_W'(SAT);
      pend_q  <= 1'b0;
      back_q  <= '0;
      fwd_q   <= '0;
    end else begin
      if (frame_i)                    since_q <= CNT_W'(1);
      else if (since_q != CNT_W'(SAT)) since_q <= since_q + CNT_W'(1);
      if (start) begin
        pend_q <= 1'b1;
        back_q <= since_q;
        fwd_q  <= CNT_W'(1);
      end else if (pend_q) begin
        pend_q <= !res_o;
        fwd_q  <= fwd_q + CNT_W'(1);
      end
    end
  end

  AST_OK_WITHIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o && !viol_o |-> int'(off_o) <= int'(win_i) && int'(off_o) >= -int'(win_i)); // R4
  AST_SINCE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_q <= CNT_W'(SAT)); // R5
  AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !res_o |=> pend_q && fwd_q == $past(fwd_q) + CNT_W'(1)); // R9
  AST_FWD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && fwd_q > win_i |-> res_o); // R4

endmodule

// File: rtl/fsam_alarm.sv
module fsam_alarm #(
  parameter int unsigned OFS_W = 6,
  parameter int          OFS_MAX = 17,
  parameter int          OFS_MIN = -16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    res_i,
  input  logic                    viol_i,
  input  logic signed [OFS_W-1:0] off_i,
  input  logic                    clr_i,
  output logic                    evt_o,
  output logic signed [OFS_W-1:0] off_o,
  output logic                    alarm_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o   <= 1'b0;
      off_o   <= '0;
      alarm_o <= 1'b0;
    end else begin
      evt_o <= res_i;
      if (res_i) off_o <= off_i;
      if (res_i && viol_i) alarm_o <= 1'b1;
      else if (clr_i)      alarm_o <= 1'b0;
    end
  end

  AST_VIOL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_i && viol_i |=> alarm_o); // R8
  AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o && !clr_i |=> alarm_o); // R7
  AST_ALARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !(res_i && viol_i) |=> !alarm_o); // R7
  AST_EVT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_i |=> !evt_o && $stable(off_o)); // R6
  AST_OFS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> int'(off_o) <= OFS_MAX && int'(off_o) >= OFS_MIN); // R5

endmodule

// File: rtl/frame_sync_mon.sv
module frame_sync_mon
  import fsam_pkg::*;
#(
  parameter int unsigned LIMIT_W = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sync_i,
  input  logic                      frame_i,
  input  logic [1:0]                phase_sel_i,
  input  logic [LIMIT_W-1:0]        limit_i,
  input  logic                      alarm_clr_i,
  output logic                      sync_evt_o,
  output logic signed [LIMIT_W+2:0] offset_o,
  output logic                      alarm_o
);

  localparam int unsigned WMAX  = 2 * (2 ** LIMIT_W);
  localparam int unsigned SAT   = WMAX + 1;
  localparam int unsigned CNT_W = LIMIT_W + 2;
  localparam int unsigned OFS_W = CNT_W + 1;

  logic [1:0]              tap;
  logic [CNT_W-1:0]        win;
  logic                    edge_a, frame_a;
  logic                    res, viol;
  logic signed [OFS_W-1:0] off;

  assign tap = tap_for(phase_sel_e'(phase_sel_i));
  assign win = (CNT_W'(limit_i) + CNT_W'(1)) << 1;

  fsam_sampler #(.TAPS(PH_TAPS)) i_sampler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .frame_i (frame_i),
    .tap_i   (tap),
    .edge_o  (edge_a),
    .frame_o (frame_a)
  );

  fsam_measure #(.CNT_W(CNT_W), .OFS_W(OFS_W), .SAT(SAT)) i_measure (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (edge_a),
    .frame_i (frame_a),
    .win_i   (win),
    .res_o   (res),
    .viol_o  (viol),
    .off_o   (off)
  );

  fsam_alarm #(.OFS_W(OFS_W), .OFS_MAX(int'(SAT)), .OFS_MIN(-int'(WMAX))) i_alarm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .res_i   (res),
    .viol_i  (viol),
    .off_i   (off),
    .clr_i   (alarm_clr_i),
    .evt_o   (sync_evt_o),
    .off_o   (offset_o),
    .alarm_o (alarm_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !sync_evt_o && !alarm_o); // R10

endmodule

// File: tb/test_frame_sync_mon.sv
`timescale 1ns/1ps
module test_frame_sync_mon;
  localparam int LIMIT_W = 3;
  localparam int SATV    = 17;
  localparam int TLEN    = 48;
  localparam int IDLE    = 30;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sync_i = 1'b1, frame_i = 1'b0, clr = 1'b0;
  logic [1:0] ph = 2'b00;
  logic [LIMIT_W-1:0] lim = 3'b010;
  logic evt, alarm;
  logic signed [LIMIT_W+2:0] ofs;

  int n_chk = 0, n_err = 0;
  bit alarm_exp = 1'b0;

  always #2.5 clk = ~clk;

  frame_sync_mon #(.LIMIT_W(LIMIT_W)) i_frame_sync_mon (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .frame_i(frame_i),
    .phase_sel_i(ph), .limit_i(lim), .alarm_clr_i(clr),
    .sync_evt_o(evt), .offset_o(ofs), .alarm_o(alarm));

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int shift_of(input logic [1:0] p);
    case (p)
      2'b01:   return -1;
      2'b10:   return 2;
      2'b11:   return 1;
      default: return 0;
    endcase
  endfunction

  // R3 R4 R5: nearest strobe, earlier wins a tie, back distance capped
  function automatic void model(input int te, input logic [TLEN-1:0] fr, input int w,
                                output int off, output bit viol);
    int b = SATV;
    int d = -1;
    for (int j = 0; j < TLEN; j++) begin
      if (fr[j]) begin
        if (j <= te && te - j < b) b = te - j;
        if (j > te && (d < 0 || j - te < d)) d = j - te;
      end
    end
    if (d >= 0 && d <= w && d < b) begin off = -d; viol = 1'b0; end
    else begin off = b; viol = b > w; end
  endfunction

  task automatic run_trial(input logic [1:0] p_sel, input logic [2:0] l, input int p,
                           input logic [TLEN-1:0] fr, input bit dbl, input bit hold_clr,
                           input string name);
    int te, w, off_e, got_n, got_off;
    bit viol_e, got_al, al_e;
    te = p + shift_of(p_sel);
    w  = 2 * (int'(l) + 1);
    model(te, fr, w, off_e, viol_e);
    got_n = 0; got_off = 0; got_al = 1'b0;
    ph = p_sel; lim = l; clr = hold_clr;
    for (int k = 0; k < TLEN + IDLE; k++) begin
      @(negedge clk);
      if (evt) begin got_n++; got_off = ofs; got_al = alarm; end
      frame_i = (k < TLEN) ? fr[k] : 1'b0;
      if (k < TLEN) sync_i = (k < p) || (dbl && k == p + 2);
      else          sync_i = 1'b1;
    end
    check(got_n == 1, {"R6/R9 event count ", name}, got_n, 1);
    check(got_off == off_e, {"R2/R3 offset ", name}, got_off, off_e);
    al_e = viol_e ? 1'b1 : (hold_clr ? 1'b0 : alarm_exp);
    check(got_al == al_e, {"R5/R8 alarm at event ", name}, got_al, al_e);
    alarm_exp = hold_clr ? 1'b0 : al_e;
    @(negedge clk);
    clr = 1'b0;
    check(alarm == alarm_exp, {"R7 alarm after trial ", name}, alarm, alarm_exp);
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    alarm_exp = 1'b0;
    check(alarm == 1'b0, "R7 clear pulse", alarm, 0);
  endtask

  function automatic logic [TLEN-1:0] at(input int a);
    logic [TLEN-1:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    return v;
  endfunction

  initial begin
    #(100000 * 5);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250601));
    repeat (3) @(negedge clk);
    check(evt == 1'b0, "R10 reset event", evt, 0);
    check(ofs == 0, "R10 reset offset", ofs, 0);
    check(alarm == 1'b0, "R10 reset alarm", alarm, 0);
    rst_ni = 1'b1;
    repeat (25) @(negedge clk);
    check(evt == 1'b0 && alarm == 1'b0, "R10 idle after reset", {evt, alarm}, 0);

    // R1 R2: same stimulus under each phase code
    run_trial(2'b00, 3'd2, 20, at(20), 0, 0, "on target");
    run_trial(2'b01, 3'd2, 20, at(20), 0, 0, "half early");
    run_trial(2'b10, 3'd2, 20, at(20), 0, 0, "one late");
    run_trial(2'b11, 3'd2, 20, at(20), 0, 0, "half late");
    // R4 R5: narrowest window edges
    run_trial(2'b00, 3'd0, 20, at(18), 0, 0, "back at W");
    run_trial(2'b00, 3'd0, 20, at(17), 0, 0, "back at W+1");
    // R7: good edge keeps alarm, then clear
    run_trial(2'b00, 3'd2, 20, at(21), 0, 0, "sticky");
    pulse_clear();
    // widest window
    run_trial(2'b00, 3'd7, 20, at(4), 0, 0, "back 16");
    run_trial(2'b00, 3'd7, 20, at(36), 0, 0, "fwd 16");
    run_trial(2'b00, 3'd7, 20, '0, 0, 0, "no strobe");
    pulse_clear();
    // R3 tie and forward preference
    run_trial(2'b00, 3'd2, 20, at(17) | at(23), 0, 0, "tie");
    run_trial(2'b00, 3'd2, 20, at(14) | at(22), 0, 0, "forward nearer");
    run_trial(2'b00, 3'd1, 20, at(10) | at(23), 0, 0, "back out fwd in");
    // R9: second edge while waiting
    run_trial(2'b00, 3'd7, 20, at(26), 1, 0, "second edge dropped");
    // R8: violation with clear held
    run_trial(2'b00, 3'd0, 20, '0, 0, 1, "viol over clear");

    for (int t = 0; t < 40; t++) begin
      logic [TLEN-1:0] fr;
      for (int j = 0; j < TLEN; j++) fr[j] = ($urandom % 14) == 0;
      run_trial(2'($urandom % 4), 3'($urandom % 8), 18 + int'($urandom % 9), fr, 0,
                ($urandom % 8) == 0, "random");
      if (alarm_exp && ($urandom % 3) == 0) pulse_clear();
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule